// File: doc/BRIEF.md
# Priority Interrupt Request Controller

This block raises one interrupt request line toward the processor whenever an enabled I/O event needs service, and reports a 3-bit code naming the source to serve first. Six system events are captured into pending flags while the master enable switch is on. These are overlapped I/O completion, seek completion, console inquiry, console output, non-overlapped seek completion and disk attention. Each pending flag stays set until the processor acknowledges it.

Unit-record devices (card reader, punch, printer, paper tape) follow an operator sequence. A 2-bit selector picks one device. A press of the priority pushbutton is synchronized, debounced and reduced to exactly one single-cycle pulse, however long the button is held. That pulse posts an initial unit-record interrupt and arms the sequencer. From then on, each completion reported by the selected device posts another unit-record interrupt. Clearing the enable switch disarms the sequencer and drops everything pending.

The button path is a state machine with five states. `BTN_IDLE` moves to `BTN_CONFIRM` when the synchronized level goes high. `BTN_CONFIRM` returns to `BTN_IDLE` if the level drops early, and moves to `BTN_FIRE` after `DEB_CYCLES` high samples. `BTN_FIRE` always moves to `BTN_HELD` after one cycle. `BTN_HELD` moves to `BTN_RELEASE` when the level goes low. `BTN_RELEASE` goes back to `BTN_HELD` if the level rises again, and to `BTN_IDLE` after `DEB_CYCLES` low samples. The unit-record sequencer has two states. `UR_IDLE` moves to `UR_ARMED` on a button pulse while enabled. `UR_ARMED` moves back to `UR_IDLE` when the enable switch is off.

Top module: `irq_prio_ctrl`

## Requirements
- R1: After reset, `irq_req` is 0 and `irq_src` is 7, the code meaning "nothing pending".
- R2: While `enable_sw` is 1, a one-cycle pulse on `io_event[i]` sets source i pending, so `irq_req` becomes 1 with `irq_src` = i. The bit assignments are: 0 overlapped I/O done, 1 seek done, 2 console inquiry, 3 console output, 4 non-overlapped seek done, 5 disk attention.
- R3: Events arriving while `enable_sw` is 0 are ignored. Driving `enable_sw` to 0 clears every pending source and disarms the unit-record sequencer.
- R4: A pending source stays pending until `irq_ack` is pulsed. An acknowledge clears only the source currently shown on `irq_src`.
- R5: When several sources are pending, `irq_src` shows the lowest code. Unit-record requests use code 6, the lowest priority.
- R6: A high level on `prio_btn` that lasts fewer than `DEB_CYCLES` synchronized samples produces no interrupt.
- R7: One press of `prio_btn` gives exactly one unit-record interrupt (code 6), however long the button is held. No further request appears while the button stays down after that interrupt is acknowledged.
- R8: After the button pulse has armed the sequencer, a pulse on `ur_done[ur_sel]` posts a code-6 request. `ur_sel` encodes 0 card reader, 1 punch, 2 printer, 3 paper tape. A completion from a device that is not selected is ignored.
- R9: A `ur_done` pulse while the sequencer is not armed is ignored.
- R10: An event that arrives in the same cycle as the acknowledge of that same source leaves the source pending.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| enable_sw | input | 1 | Master interrupt enable switch |
| io_event | input | 6 | System event pulses, one bit per source code 0..5 |
| ur_sel | input | 2 | Unit-record device selector |
| ur_done | input | 4 | Completion pulse per unit-record device |
| prio_btn | input | 1 | Raw priority pushbutton level |
| irq_ack | input | 1 | Interrupt acknowledge pulse |
| irq_req | output | 1 | Interrupt request to the processor |
| irq_src | output | 3 | Code of the highest-priority pending source, 7 if none |

## Verification
The bench holds the button far longer than the debounce window and then acknowledges while it is still down. A one-shot that re-fired on level, or a missing held state, would show a second code-6 request. A short glitch on the button checks that a design without debouncing would post a spurious interrupt. Completions from an unselected device, and completions before arming or after a disable, probe sequencers that trigger on any device or keep their arm state across an enable drop. An acknowledge that collides with a new event on the same source exposes designs where the clear wins and the event is lost. Two simultaneous sources check that the acknowledge clears only the reported one, in priority order.

// File: rtl/irq_pkg.sv
package irq_pkg;
    localparam int N_SYS    = 6;
    localparam int N_UR     = 4;
    localparam int N_SRC    = N_SYS + 1;
    localparam int SRC_W    = $clog2(N_SRC + 1);
    localparam int UR_SEL_W = $clog2(N_UR);

    localparam logic [SRC_W-1:0] SRC_UR   = SRC_W'(N_SYS);
    localparam logic [SRC_W-1:0] SRC_NONE = {SRC_W{1'b1}};

    typedef enum logic [2:0] {
        BTN_IDLE,
        BTN_CONFIRM,
        BTN_FIRE,
        BTN_HELD,
        BTN_RELEASE
    } btn_state_t;

    typedef enum logic [0:0] {
        UR_IDLE,
        UR_ARMED
    } ur_state_t;
endpackage

// File: rtl/irq_btn_oneshot.sv
module irq_btn_oneshot
    import irq_pkg::*;
#(
    parameter int DEB_CYCLES = 4,
    parameter int SYNC_STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic btn_raw,
    output logic pulse
);
    localparam int CNT_W = $clog2(DEB_CYCLES + 1);
    localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(DEB_CYCLES - 1);

    logic [SYNC_STAGES-1:0] sync_q;
    logic                   btn_s;
    btn_state_t             state_q, state_d;
    logic [CNT_W-1:0]       cnt_q, cnt_d;

    // input synchronizer chain
    always_ff @(posedge clk) begin
        if (!rst_n) sync_q <= '0;
        else        sync_q <= {sync_q[SYNC_STAGES-2:0], btn_raw};
    end
    assign btn_s = sync_q[SYNC_STAGES-1];

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= BTN_IDLE;
            cnt_q   <= '0;
        end else begin
            state_q <= state_d;
            cnt_q   <= cnt_d;
        end
    end

    // next state
    always_comb begin
        state_d = state_q;
        cnt_d   = cnt_q;
        unique case (state_q)
            BTN_IDLE: begin
                cnt_d = '0;
                if (btn_s) state_d = BTN_CONFIRM;
            end
            BTN_CONFIRM: begin
                if (!btn_s) begin
                    state_d = BTN_IDLE;
                    cnt_d   = '0;
                end else if (cnt_q == CNT_LAST) begin
                    state_d = BTN_FIRE;
                    cnt_d   = '0;
                end else begin
                    cnt_d = cnt_q + 1'b1;
                end
            end
            BTN_FIRE: begin
                state_d = BTN_HELD;
                cnt_d   = '0;
            end
            BTN_HELD: begin
                cnt_d = '0;
                if (!btn_s) state_d = BTN_RELEASE;
            end
            BTN_RELEASE: begin
                if (btn_s) begin
                    state_d = BTN_HELD;
                    cnt_d   = '0;
                end else if (cnt_q == CNT_LAST) begin
                    state_d = BTN_IDLE;
                    cnt_d   = '0;
                end else begin
                    cnt_d = cnt_q + 1'b1;
                end
            end
            default: begin
                state_d = BTN_IDLE;
                cnt_d   = '0;
            end
        endcase
    end

    // outputs
    always_comb begin
        pulse = (state_q == BTN_FIRE);
    end
endmodule

// File: rtl/irq_ur_seq.sv
module irq_ur_seq
    import irq_pkg::*;
(
    input  logic                clk,
    input  logic                rst_n,
    input  logic                enable,
    input  logic                btn_pulse,
    input  logic [UR_SEL_W-1:0] ur_sel,
    input  logic [N_UR-1:0]     ur_done,
    output logic                ur_set,
    output logic                armed
);
    ur_state_t state_q, state_d;

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= UR_IDLE;
        else        state_q <= state_d;
    end

    // next state
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            UR_IDLE:  if (enable && btn_pulse) state_d = UR_ARMED;
            UR_ARMED: if (!enable)             state_d = UR_IDLE;
            default:                           state_d = UR_IDLE;
        endcase
    end

    // outputs
    always_comb begin
        armed  = (state_q == UR_ARMED);
        ur_set = 1'b0;
        unique case (state_q)
            UR_IDLE:  ur_set = enable && btn_pulse;
            UR_ARMED: ur_set = enable && (btn_pulse || ur_done[ur_sel]);
            default:  ur_set = 1'b0;
        endcase
    end
endmodule

// File: rtl/irq_pending.sv
module irq_pending
    import irq_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             enable,
    input  logic [N_SRC-1:0] set_vec,
    input  logic             ack,
    output logic             req,
    output logic [SRC_W-1:0] src
);
    logic [N_SRC-1:0] pend_q, pend_d, clr_mask;

    // lowest-index pending source wins
    always_comb begin
        src      = SRC_NONE;
        clr_mask = '0;
        for (int i = N_SRC - 1; i >= 0; i--) begin
            if (pend_q[i]) begin
                src      = SRC_W'(i);
                clr_mask = N_SRC'(1) << i;
            end
        end
    end

    // a new event on the same cycle as its ack keeps the flag set
    always_comb begin
        if (!enable) pend_d = '0;
        else         pend_d = (pend_q & ~(ack ? clr_mask : '0)) | set_vec;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) pend_q <= '0;
        else        pend_q <= pend_d;
    end

    assign req = |pend_q;
endmodule

// File: rtl/irq_prio_ctrl.sv
module irq_prio_ctrl
    import irq_pkg::*;
#(
    parameter int DEB_CYCLES = 4
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                enable_sw,
    input  logic [N_SYS-1:0]    io_event,
    input  logic [UR_SEL_W-1:0] ur_sel,
    input  logic [N_UR-1:0]     ur_done,
    input  logic                prio_btn,
    input  logic                irq_ack,
    output logic                irq_req,
    output logic [SRC_W-1:0]    irq_src
);
    logic             btn_pulse;
    logic             ur_set;
    logic             ur_armed;
    logic [N_SRC-1:0] set_vec;

    irq_btn_oneshot #(.DEB_CYCLES(DEB_CYCLES), .SYNC_STAGES(2)) i_btn (
        .clk     (clk),
        .rst_n   (rst_n),
        .btn_raw (prio_btn),
        .pulse   (btn_pulse)
    );

    irq_ur_seq i_ur (
        .clk       (clk),
        .rst_n     (rst_n),
        .enable    (enable_sw),
        .btn_pulse (btn_pulse),
        .ur_sel    (ur_sel),
        .ur_done   (ur_done),
        .ur_set    (ur_set),
        .armed     (ur_armed)
    );

    assign set_vec = {ur_set, io_event & {N_SYS{enable_sw}}};

    irq_pending i_pend (
        .clk     (clk),
        .rst_n   (rst_n),
        .enable  (enable_sw),
        .set_vec (set_vec),
        .ack     (irq_ack),
        .req     (irq_req),
        .src     (irq_src)
    );
endmodule

// File: rtl/irq_prio_ctrl_chk.sv
module irq_prio_ctrl_chk
    import irq_pkg::*;
(
    input logic             clk,
    input logic             rst_n,
    input logic             enable_sw,
    input logic             irq_ack,
    input logic             irq_req,
    input logic [SRC_W-1:0] irq_src,
    input logic             btn_pulse,
    input logic             ur_armed
);
    // R7
    pulse_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
        btn_pulse |=> !btn_pulse);

    // R3
    disable_clears_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !enable_sw |=> !irq_req);

    // R4
    req_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (irq_req && !irq_ack && enable_sw) |=> irq_req);

    // R8
    arm_from_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(ur_armed) |-> $past(btn_pulse));

    // R5
    src_valid_chk: assert property (@(posedge clk) disable iff (!rst_n)
        irq_req |-> (irq_src <= SRC_UR));
endmodule

bind irq_prio_ctrl irq_prio_ctrl_chk i_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .enable_sw (enable_sw),
    .irq_ack   (irq_ack),
    .irq_req   (irq_req),
    .irq_src   (irq_src),
    .btn_pulse (btn_pulse),
    .ur_armed  (ur_armed)
);

// File: tb/test_irq_prio_ctrl.sv
`timescale 1ns/1ps
module test_irq_prio_ctrl;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       enable_sw = 1'b0;
    logic [5:0] io_event = '0;
    logic [1:0] ur_sel = '0;
    logic [3:0] ur_done = '0;
    logic       prio_btn = 1'b0;
    logic       irq_ack = 1'b0;
    logic       irq_req;
    logic [2:0] irq_src;

    int n_cmp = 0;
    int n_bad = 0;
    bit done = 1'b0;

    always #2.5 clk = ~clk;

    irq_prio_ctrl #(.DEB_CYCLES(4)) i_irq_prio_ctrl (
        .clk(clk), .rst_n(rst_n), .enable_sw(enable_sw), .io_event(io_event),
        .ur_sel(ur_sel), .ur_done(ur_done), .prio_btn(prio_btn),
        .irq_ack(irq_ack), .irq_req(irq_req), .irq_src(irq_src)
    );

    task automatic check(input string req, input logic exp_req, input logic [2:0] exp_src);
        n_cmp++;
        if (irq_req !== exp_req || irq_src !== exp_src) begin
            n_bad++;
            $display("FAIL %s: got req=%0b src=%0d, expected req=%0b src=%0d",
                     req, irq_req, irq_src, exp_req, exp_src);
        end
    endtask

    task automatic wait_cyc(input int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    task automatic pulse_event(input int idx);
        @(negedge clk); io_event[idx] = 1'b1;
        @(negedge clk); io_event = '0;
    endtask

    task automatic pulse_done(input int idx);
        @(negedge clk); ur_done[idx] = 1'b1;
        @(negedge clk); ur_done = '0;
    endtask

    task automatic do_ack();
        @(negedge clk); irq_ack = 1'b1;
        @(negedge clk); irq_ack = 1'b0;
    endtask

    task automatic t_reset();
        wait_cyc(1);
        check("R1 reset", 1'b0, 3'd7);
    endtask

    task automatic t_sys_events();
        for (int i = 0; i < 6; i++) begin
            pulse_event(i);
            check("R2 event code", 1'b1, 3'(i));
            wait_cyc(3);
            check("R4 held until ack", 1'b1, 3'(i));
            do_ack();
            check("R4 cleared by ack", 1'b0, 3'd7);
        end
    endtask

    task automatic t_priority();
        @(negedge clk); io_event = 6'b010010;
        @(negedge clk); io_event = '0;
        check("R5 lowest first", 1'b1, 3'd1);
        do_ack();
        check("R4 ack clears only shown", 1'b1, 3'd4);
        do_ack();
        check("R5 all served", 1'b0, 3'd7);
    endtask

    task automatic t_disabled();
        @(negedge clk); enable_sw = 1'b0;
        pulse_event(3);
        check("R3 ignored when off", 1'b0, 3'd7);
        @(negedge clk); enable_sw = 1'b1;
        pulse_event(5);
        check("R2 re-enabled", 1'b1, 3'd5);
        @(negedge clk); enable_sw = 1'b0;
        @(negedge clk); enable_sw = 1'b1;
        check("R3 disable clears", 1'b0, 3'd7);
    endtask

    task automatic t_collision();
        pulse_event(2);
        @(negedge clk); irq_ack = 1'b1; io_event[2] = 1'b1;
        @(negedge clk); irq_ack = 1'b0; io_event = '0;
        check("R10 event beats ack", 1'b1, 3'd2);
        do_ack();
        check("R10 then cleared", 1'b0, 3'd7);
    endtask

    task automatic t_ur_unarmed();
        @(negedge clk); ur_sel = 2'd0;
        pulse_done(0);
        wait_cyc(2);
        check("R9 done before arm", 1'b0, 3'd7);
    endtask

    task automatic t_button_glitch();
        @(negedge clk); prio_btn = 1'b1;
        wait_cyc(2);
        prio_btn = 1'b0;
        wait_cyc(15);
        check("R6 short glitch", 1'b0, 3'd7);
        pulse_done(0);
        check("R6 still unarmed", 1'b0, 3'd7);
    endtask

    task automatic t_ur_sequence();
        @(negedge clk); ur_sel = 2'd2; prio_btn = 1'b1;
        wait_cyc(15);
        check("R7 initial ur irq", 1'b1, 3'd6);
        do_ack();
        wait_cyc(30);
        check("R7 no refire while held", 1'b0, 3'd7);
        prio_btn = 1'b0;
        wait_cyc(15);
        check("R7 no refire on release", 1'b0, 3'd7);
        pulse_done(2);
        check("R8 selected done", 1'b1, 3'd6);
        do_ack();
        pulse_done(1);
        wait_cyc(1);
        check("R8 unselected ignored", 1'b0, 3'd7);
        @(negedge clk); ur_sel = 2'd1;
        pulse_done(1);
        check("R8 new selection", 1'b1, 3'd6);
        do_ack();
        @(negedge clk); enable_sw = 1'b0;
        @(negedge clk); enable_sw = 1'b1;
        pulse_done(1);
        check("R3 disable disarms", 1'b0, 3'd7);
    endtask

    initial begin
        wait_cyc(3);
        rst_n = 1'b1;
        t_reset();
        enable_sw = 1'b1;
        t_sys_events();
        t_priority();
        t_disabled();
        t_collision();
        t_ur_unarmed();
        t_button_glitch();
        t_ur_sequence();
        done = 1'b1;
    end

    initial begin
        fork
            wait (done);
            begin
                repeat (20000) @(posedge clk);
                n_cmp++;
                n_bad++;
                $display("FAIL watchdog: got timeout, expected completion");
            end
        join_any
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end
endmodule